// File: doc/BRIEF.md
# PTP System Time Counter

This block keeps a precision time-protocol clock as a seconds count and a nanoseconds count, both advanced from a reference clock. In fine mode a 32-bit accumulator adds a programmable addend on every reference clock. The nanoseconds advance by a programmable sub-second increment only on a clock where that sum carries out. Software therefore trims the clock rate by rewriting the addend, which it sets to 2^32 times the effective tick rate divided by the reference clock rate. In coarse mode the increment is added on every clock.

Software reaches the block through a simple word-addressed register port. Writes take effect on the clock edge. Reads are combinational. The address map is: 0 control, 1 increment, 2 addend, 3 update seconds, 4 update nanoseconds, 5 live seconds, 6 nanoseconds snapshot. The control word has these bits: 0 initialise, 1 offset update, 2 addend load, 4 decimal rollover (1) or binary rollover (0), and 5 fine mode (1) or coarse mode (0). The three command bits clear themselves on the clock edge that executes them.

An offset update treats the update registers as a signed value, and bit 31 of update-nanoseconds set to 1 means subtract. For a subtraction by S seconds and m nanoseconds, software writes -S in two's complement to update-seconds. To update-nanoseconds it writes bit 31 set with (1,000,000,000 - m) in decimal mode, or (0x80000000 - m) in binary mode. The block then borrows from or carries into seconds as needed.

Top module: `ptp_systime`

## Requirements
- R1: After reset the time is 0 s / 0 ns, the addend is 0, the increment is the default, and the control word (address 0) reads 0x30: fine mode (bit 5) and decimal rollover (bit 4) set, with command bits 0..2 clear.
- R2: In fine mode the time advances only on a clock where the 32-bit accumulator plus the active addend carries out. With an active addend of 0 the time stays frozen. With 0x80000000 it advances by exactly 5 increments over any 10 clocks.
- R3: In coarse mode (control bit 5 = 0) the nanoseconds advance by the increment on every clock.
- R4: The increment register (address 1, 8 bits) resets to 20 ns, or to 10 ns when the ALT_TICK parameter is 1. A written value is used from the next clock.
- R5: With decimal rollover, nanoseconds wrap after 999,999,999 and seconds increment.
- R6: With binary rollover, nanoseconds wrap at 2^31 and seconds increment. A value such as 999,999,990 does not wrap.
- R7: Writing control bit 0 copies update-seconds and update-nanoseconds (addresses 3 and 4) into the time on the next clock.
- R8: Writing control bit 1 with update-nanoseconds bit 31 clear adds the update registers to the time. A nanosecond sum past the rollover limit carries into seconds.
- R9: Writing control bit 1 with bit 31 set subtracts the encoded offset. This works in both decimal and binary mode and borrows a second when the nanoseconds underflow.
- R10: A write to the addend register (address 2) has no effect on the rate until control bit 2 is written. The new addend governs the accumulator from the next clock.
- R11: Each command bit reads back as 1 for exactly one clock after the write and then reads 0.
- R12: A control write that arrives while any command bit is set is ignored as a whole, including its command and mode bits.
- R13: A read of address 5 with rd_en returns the live seconds and latches the nanoseconds of the same instant. Address 6 returns that snapshot, so a pair never straddles a seconds rollover.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; latches the nanosecond snapshot on a seconds read |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Combinational read data |

## Verification
The hardest cases to reach are a rollover or a negative offset landing on an exact value. Free-running time makes the cycle of each event hard to pin down. The stimulus first freezes the clock by loading an addend of zero in fine mode. With time held still, every initialise and offset result can be compared to an exact seconds and nanoseconds pair. Rollover and snapshot tests then switch to coarse mode just below the wrap point. There the result is checked against the arithmetic progression of the increment rather than a single cycle count.

// File: rtl/ptp_systime_pkg.sv
package ptp_systime_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NS_W   = 32;

  localparam logic [ADDR_W-1:0] RA_CTRL     = 3'd0;
  localparam logic [ADDR_W-1:0] RA_INCR     = 3'd1;
  localparam logic [ADDR_W-1:0] RA_ADDEND   = 3'd2;
  localparam logic [ADDR_W-1:0] RA_UPD_SEC  = 3'd3;
  localparam logic [ADDR_W-1:0] RA_UPD_NS   = 3'd4;
  localparam logic [ADDR_W-1:0] RA_TIME_SEC = 3'd5;
  localparam logic [ADDR_W-1:0] RA_TIME_NS  = 3'd6;

  localparam int unsigned CB_DEC  = 4;
  localparam int unsigned CB_FINE = 5;

  localparam logic [NS_W:0] DEC_LIMIT = 33'd1_000_000_000;
  localparam logic [NS_W:0] BIN_LIMIT = 33'h0_8000_0000;

  typedef struct packed {
    logic load;
    logic offs;
    logic init;
  } cmd_t;
endpackage

// File: rtl/ptp_systime_regs.sv
module ptp_systime_regs
  import ptp_systime_pkg::*;
#(
  parameter int unsigned SEC_W   = 32,
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned INC_W   = 8,
  parameter int unsigned DEF_INC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output cmd_t              cmd,
  output logic              dec_mode,
  output logic              fine_mode,
  output logic [INC_W-1:0]  incr,
  output logic [ACC_W-1:0]  addend,
  output logic [SEC_W-1:0]  upd_sec,
  output logic [NS_W-1:0]   upd_ns,
  output logic [DATA_W-1:0] ctrl_word
);
  cmd_t             cmd_q, cmd_n;
  logic             dec_q, dec_n, fine_q, fine_n;
  logic [INC_W-1:0] inc_q, inc_n;
  logic [ACC_W-1:0] add_q, add_n;
  logic [SEC_W-1:0] usec_q, usec_n;
  logic [NS_W-1:0]  uns_q, uns_n;
  logic             busy;

  assign busy = |cmd_q;

  always_comb begin
    cmd_n  = '0;
    dec_n  = dec_q;
    fine_n = fine_q;
    inc_n  = inc_q;
    add_n  = add_q;
    usec_n = usec_q;
    uns_n  = uns_q;
    if (wr_en) begin
      unique case (wr_addr)
        RA_CTRL: if (!busy) begin
          cmd_n  = cmd_t'(wr_data[2:0]);
          dec_n  = wr_data[CB_DEC];
          fine_n = wr_data[CB_FINE];
        end
        RA_INCR:    inc_n  = wr_data[INC_W-1:0];
        RA_ADDEND:  add_n  = wr_data[ACC_W-1:0];
        RA_UPD_SEC: usec_n = wr_data[SEC_W-1:0];
        RA_UPD_NS:  uns_n  = wr_data[NS_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      dec_q  <= 1'b1;
      fine_q <= 1'b1;
      inc_q  <= INC_W'(DEF_INC);
      add_q  <= '0;
      usec_q <= '0;
      uns_q  <= '0;
    end else begin
      cmd_q  <= cmd_n;
      dec_q  <= dec_n;
      fine_q <= fine_n;
      inc_q  <= inc_n;
      add_q  <= add_n;
      usec_q <= usec_n;
      uns_q  <= uns_n;
    end
  end

  assign cmd       = cmd_q;
  assign dec_mode  = dec_q;
  assign fine_mode = fine_q;
  assign incr      = inc_q;
  assign addend    = add_q;
  assign upd_sec   = usec_q;
  assign upd_ns    = uns_q;
  assign ctrl_word = DATA_W'({fine_q, dec_q, 1'b0, cmd_q.load, cmd_q.offs, cmd_q.init});

  // R11: a command bit never survives the clock that executes it
  assert_cmd_selfclear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R12: a control write arriving while busy leaves the modes untouched
  assert_busy_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_addr == RA_CTRL) |=> ($stable(dec_q) && $stable(fine_q) && !busy));
endmodule

// File: rtl/ptp_systime_tick.sv
module ptp_systime_tick
  import ptp_systime_pkg::*;
#(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fine_mode,
  input  logic             load,
  input  logic [ACC_W-1:0] addend_reg,
  output logic             tick
);
  logic [ACC_W-1:0] acc_q, acc_n;
  logic [ACC_W-1:0] act_q, act_n;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, act_q};

  always_comb begin
    acc_n = sum[ACC_W-1:0];
    act_n = load ? addend_reg : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      act_q <= '0;
    end else begin
      acc_q <= acc_n;
      act_q <= act_n;
    end
  end

  assign tick = fine_mode ? sum[ACC_W] : 1'b1;

  // R10: the load command moves the programmed addend into the accumulator path
  assert_addend_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (act_q == $past(addend_reg)));

  // R2: with a zero active addend the fine-mode tick never fires
  assert_zero_addend_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fine_mode && act_q == '0) |-> !tick);
endmodule

// File: rtl/ptp_systime_core.sv
module ptp_systime_core
  import ptp_systime_pkg::*;
#(
  parameter int unsigned SEC_W = 32,
  parameter int unsigned INC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             dec_mode,
  input  cmd_t             cmd,
  input  logic [INC_W-1:0] incr,
  input  logic [SEC_W-1:0] upd_sec,
  input  logic [NS_W-1:0]  upd_ns,
  output logic [SEC_W-1:0] sec,
  output logic [NS_W-1:0]  ns
);
  logic [SEC_W-1:0] sec_q, sec_n;
  logic [NS_W-1:0]  ns_q, ns_n;
  logic [NS_W:0]    lim, tick_sum, ofs_sum;
  logic             ofs_ge, ofs_neg;

  assign lim      = dec_mode ? DEC_LIMIT : BIN_LIMIT;
  assign tick_sum = {1'b0, ns_q} + (NS_W+1)'(incr);
  assign ofs_sum  = {1'b0, ns_q} + {2'b00, upd_ns[NS_W-2:0]};
  assign ofs_ge   = (ofs_sum >= lim);
  assign ofs_neg  = upd_ns[NS_W-1];

  always_comb begin
    sec_n = sec_q;
    ns_n  = ns_q;
    if (cmd.init) begin
      sec_n = upd_sec;
      ns_n  = upd_ns;
    end else if (cmd.offs) begin
      ns_n  = ofs_ge ? NS_W'(ofs_sum - lim) : NS_W'(ofs_sum);
      sec_n = sec_q + upd_sec + SEC_W'(ofs_ge) - SEC_W'(ofs_neg);
    end else if (tick) begin
      if (tick_sum >= lim) begin
        ns_n  = NS_W'(tick_sum - lim);
        sec_n = sec_q + SEC_W'(1);
      end else begin
        ns_n  = NS_W'(tick_sum);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else begin
      sec_q <= sec_n;
      ns_q  <= ns_n;
    end
  end

  assign sec = sec_q;
  assign ns  = ns_q;

  // R2: without a tick or a time command the time holds
  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cmd.init && !cmd.offs) |=> ($stable(sec_q) && $stable(ns_q)));

  // R7: initialise copies the update registers
  assert_init_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.init |=> (sec_q == $past(upd_sec) && ns_q == $past(upd_ns)));

  // R5: decimal nanoseconds stay below one second while ticking
  assert_dec_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_mode && !cmd.init && !cmd.offs && ns_q < NS_W'(DEC_LIMIT)) |=> (ns_q < NS_W'(DEC_LIMIT)));

  // R6: binary nanoseconds stay below 2^31 while ticking
  assert_bin_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_mode && !cmd.init && !cmd.offs && !ns_q[NS_W-1]) |=> !ns_q[NS_W-1]);
endmodule

// File: rtl/ptp_systime.sv
module ptp_systime
  import ptp_systime_pkg::*;
#(
  parameter int unsigned SEC_W    = 32,
  parameter int unsigned ACC_W    = 32,
  parameter int unsigned INC_W    = 8,
  parameter bit          ALT_TICK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned DEF_INC = ALT_TICK ? 10 : 20;

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  cmd_t             cmd;
  logic             dec_mode, fine_mode, tick;
  logic [INC_W-1:0] incr;
  logic [ACC_W-1:0] addend;
  logic [SEC_W-1:0] upd_sec, sys_sec;
  logic [NS_W-1:0]  upd_ns, sys_ns;
  logic [DATA_W-1:0] ctrl_word;
  logic [NS_W-1:0]  snap_q, snap_n;
  logic             snap_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  ptp_systime_regs #(.SEC_W(SEC_W), .ACC_W(ACC_W), .INC_W(INC_W), .DEF_INC(DEF_INC)) regs_i (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd(cmd), .dec_mode(dec_mode), .fine_mode(fine_mode), .incr(incr), .addend(addend),
    .upd_sec(upd_sec), .upd_ns(upd_ns), .ctrl_word(ctrl_word));

  ptp_systime_tick #(.ACC_W(ACC_W)) tick_i (
    .clk(clk), .rst_n(rst_core_n), .fine_mode(fine_mode), .load(cmd.load),
    .addend_reg(addend), .tick(tick));

  ptp_systime_core #(.SEC_W(SEC_W), .INC_W(INC_W)) core_i (
    .clk(clk), .rst_n(rst_core_n), .tick(tick), .dec_mode(dec_mode), .cmd(cmd),
    .incr(incr), .upd_sec(upd_sec), .upd_ns(upd_ns), .sec(sys_sec), .ns(sys_ns));

  assign snap_take = rd_en && (rd_addr == RA_TIME_SEC);

  always_comb begin
    snap_n = snap_take ? sys_ns : snap_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) snap_q <= '0;
    else             snap_q <= snap_n;
  end

  always_comb begin
    unique case (rd_addr)
      RA_CTRL:     rd_data = ctrl_word;
      RA_INCR:     rd_data = DATA_W'(incr);
      RA_ADDEND:   rd_data = DATA_W'(addend);
      RA_UPD_SEC:  rd_data = DATA_W'(upd_sec);
      RA_UPD_NS:   rd_data = DATA_W'(upd_ns);
      RA_TIME_SEC: rd_data = DATA_W'(sys_sec);
      RA_TIME_NS:  rd_data = DATA_W'(snap_q);
      default:     rd_data = '0;
    endcase
  end

  // R13: a seconds read captures the nanoseconds of the same instant
  assert_snapshot_coherent_R13: assert property (@(posedge clk) disable iff (!rst_core_n)
    snap_take |=> (snap_q == $past(sys_ns)));
endmodule

// File: tb/ptp_systime_tb_top.sv
module ptp_systime_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ptp_systime dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  localparam logic [2:0] A_CTRL = 3'd0, A_INCR = 3'd1, A_ADD = 3'd2, A_USEC = 3'd3,
                         A_UNS = 3'd4, A_SEC = 3'd5, A_NS = 3'd6;

  function automatic logic [31:0] ctl(bit init, bit offs, bit load, bit dec, bit fine);
    return {26'd0, fine, dec, 1'b0, load, offs, init};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic snap(output logic [31:0] s, output logic [31:0] n);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = A_SEC;
    #1 s = rd_data;
    @(posedge clk);
    #1 rd_en = 1'b0; rd_addr = A_NS;
    #1 n = rd_data;
  endtask

  task automatic freeze(input bit dec);
    wr(A_ADD, 32'd0);
    wr(A_CTRL, ctl(0, 0, 1, dec, 1));
  endtask

  task automatic set_time(input bit dec, input bit fine, input logic [31:0] s, input logic [31:0] n);
    wr(A_USEC, s);
    wr(A_UNS, n);
    wr(A_CTRL, ctl(1, 0, 0, dec, fine));
    @(posedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v, s, n;
    rd(A_CTRL, v);  chk(v == 32'h30, "R1 ctrl", v, 32'h30);
    rd(A_INCR, v);  chk(v == 32'd20, "R4 default incr", v, 20);
    rd(A_ADD, v);   chk(v == 32'd0, "R1 addend", v, 0);
    snap(s, n);
    chk(s == 0 && n == 0, "R1 time", n, 0);
    repeat (10) @(posedge clk);
    snap(s, n);
    chk(s == 0 && n == 0, "R2 frozen after reset", n, 0);
  endtask

  task automatic t_init_selfclear();
    logic [31:0] v, s, n;
    freeze(1);
    wr(A_USEC, 32'd42);
    wr(A_UNS, 32'd123);
    wr(A_CTRL, ctl(1, 0, 0, 1, 1));
    rd(A_CTRL, v);  chk(v[0] == 1'b1, "R11 init bit visible", v, 32'h31);
    @(posedge clk);
    #1;
    rd(A_CTRL, v);  chk(v == 32'h30, "R11 init bit cleared", v, 32'h30);
    snap(s, n);
    chk(s == 42, "R7 init seconds", s, 42);
    chk(n == 123, "R7 init nanoseconds", n, 123);
  endtask

  task automatic t_busy();
    logic [31:0] v, s, n;
    freeze(1);
    wr(A_USEC, 32'd100);
    wr(A_UNS, 32'd5);
    wr(A_CTRL, ctl(1, 0, 0, 1, 1));
    wr(A_CTRL, ctl(0, 1, 0, 0, 0));
    repeat (2) @(posedge clk);
    snap(s, n);
    chk(s == 100 && n == 5, "R12 busy offset ignored", n, 5);
    rd(A_CTRL, v);  chk(v == 32'h30, "R12 busy modes ignored", v, 32'h30);
  endtask

  task automatic do_offset(input bit dec, input logic [31:0] s0, input logic [31:0] n0,
                           input logic [31:0] ds, input logic [31:0] dn,
                           input logic [31:0] es, input logic [31:0] en, input string req);
    logic [31:0] s, n;
    freeze(dec);
    set_time(dec, 1, s0, n0);
    wr(A_USEC, ds);
    wr(A_UNS, dn);
    wr(A_CTRL, ctl(0, 1, 0, dec, 1));
    @(posedge clk);
    snap(s, n);
    chk(s == es, {req, " seconds"}, s, es);
    chk(n == en, {req, " nanoseconds"}, n, en);
  endtask

  task automatic t_offsets();
    do_offset(1, 10, 900_000_000, 2, 200_000_000, 13, 100_000_000, "R8 positive carry");
    do_offset(1, 10, 100_000_000, 0, 32'h8000_0000 | 32'd700_000_000, 9, 800_000_000, "R9 negative borrow");
    do_offset(1, 10, 500_000_000, 32'hFFFF_FFFD, 32'h8000_0000 | 32'd800_000_000, 7, 300_000_000, "R9 negative no borrow");
    do_offset(0, 5, 32'h100, 0, 32'h8000_0000 | 32'h7FFF_FE00, 4, 32'h7FFF_FF00, "R9 binary borrow");
    do_offset(0, 5, 32'h7FFF_FF00, 0, 32'h200, 6, 32'h100, "R8 binary carry");
  endtask

  task automatic t_coarse();
    logic [31:0] s1, n1, s2, n2;
    freeze(1);
    wr(A_INCR, 32'd10);
    set_time(1, 0, 0, 0);
    snap(s1, n1);
    snap(s2, n2);
    chk(n2 - n1 == 10, "R3 R4 coarse step 10", n2 - n1, 10);
    wr(A_INCR, 32'd20);
    snap(s1, n1);
    repeat (9) @(posedge clk);
    snap(s2, n2);
    chk(n2 - n1 == 200, "R3 R4 coarse ten steps of 20", n2 - n1, 200);
  endtask

  task automatic t_fine();
    logic [31:0] s1, n1, s2, n2, v;
    freeze(1);
    set_time(1, 1, 0, 0);
    wr(A_ADD, 32'h8000_0000);
    snap(s1, n1);
    repeat (9) @(posedge clk);
    snap(s2, n2);
    chk(n2 == n1, "R10 addend write without load", n2 - n1, 0);
    wr(A_CTRL, ctl(0, 0, 1, 1, 1));
    rd(A_ADD, v);   chk(v == 32'h8000_0000, "R10 addend register", v, 32'h8000_0000);
    @(posedge clk);
    snap(s1, n1);
    repeat (9) @(posedge clk);
    snap(s2, n2);
    chk(n2 - n1 == 100, "R2 half-rate accumulator", n2 - n1, 100);
  endtask

  task automatic t_rollover();
    logic [31:0] s, n;
    freeze(1);
    set_time(1, 0, 7, 999_999_990);
    repeat (3) @(posedge clk);
    snap(s, n);
    chk(s == 8 && n % 20 == 10 && n < 300, "R5 decimal wrap", n, 10);
    freeze(0);
    set_time(0, 0, 7, 999_999_990);
    repeat (3) @(posedge clk);
    snap(s, n);
    chk(s == 7 && n > 999_999_990 && n % 20 == 10, "R6 no decimal wrap in binary", n, 1_000_000_010);
    freeze(0);
    set_time(0, 0, 7, 32'h7FFF_FFF6);
    repeat (3) @(posedge clk);
    snap(s, n);
    chk(s == 8 && n % 20 == 10 && n < 300, "R6 binary wrap", n, 10);
  endtask

  task automatic t_snapshot();
    logic [31:0] s, n;
    freeze(1);
    set_time(1, 0, 7, 999_999_930);
    for (int i = 0; i < 6; i++) begin
      snap(s, n);
      if (s == 7)
        chk(n >= 999_999_930 && n < 1_000_000_000 && n % 20 == 10, "R13 pair before wrap", n, 999_999_990);
      else
        chk(s == 8 && n < 200 && n % 20 == 10, "R13 pair after wrap", n, 10);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_init_selfclear();
    t_busy();
    t_offsets();
    t_coarse();
    t_fine();
    t_rollover();
    t_snapshot();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule